// File: doc/BRIEF.md
# Speculative Load Deferral Decision Unit

This block rules on every executed load in a single cycle. It looks at whether the load is speculative and at its list of exception conditions. Each condition arrives as a hit bit, optionally tagged as precluded or as deferred by control-register setting. The block also looks at the page memory attribute, the code page's deferral permit, the spontaneous-deferral controls and a one-shot deferral bit. From these it picks one of three outcomes:

- raise a fault, with the priority code of the winning condition;
- write a deferred-exception token into the load's target register;
- let the load complete normally.

The result is registered and shown as a one-hot {fault, token, normal} triple one cycle after the load is presented. On a fault, two interruption status bits are captured: whether the load was speculative, and the code page's deferral permit. Software can set or clear the one-shot deferral bit. The bit covers exactly one speculative load and then clears itself.

The decision is held in a four-state machine whose state is the outcome shown this cycle:

- States: `ST_IDLE` (no load last cycle), `ST_FAULT`, `ST_TOKEN`, `ST_NORMAL`.
- Every state goes to `ST_IDLE` when no load is presented.
- With a load present, every state goes to the outcome state chosen by the decision order. The transition names are "fault-take", "token-defer" and "load-complete".

Top module: `spec_ld_defer_unit`

## Requirements
- R1: One cycle after a cycle with `ld_valid`=1, exactly one of `res_fault`, `res_token`, `res_normal` is 1. One cycle after a cycle with `ld_valid`=0, all three are 0.
- R2: For a speculative load with the one-shot bit clear, a condition is live when its `cond_hit` bit is 1 and its `cond_precl` and `cond_dcr` bits are 0. If any condition is live, the result is a fault. `fault_code` is the lowest live index, and index 0 has the highest priority.
- R3: A condition tagged by `cond_dcr` or `cond_precl` takes no part in priority selection on a speculative load, so a lower-priority live condition wins over it.
- R4: For a speculative load with the one-shot bit clear, if conditions are present but none is live, the result is a token write.
- R5: For a speculative load with the one-shot bit clear and no conditions, a `page_attr` of 1 (uncacheable), 2 (limited speculation) or 3 (reserved, handled as uncacheable) gives a token write. A `page_attr` of 0 (cacheable) moves on to R6.
- R6: In the R5 case on a cacheable page, the result is a token write when `spont_en` and `spont_allow` are both 1, and a normal completion otherwise.
- R7: A non-speculative load never gets a token write. Any condition with `cond_precl`=0 faults, whatever its `cond_dcr` tag. Otherwise the load completes normally, whatever the page attribute or spontaneous controls.
- R8: With each fault, `isr_spec` takes `ld_spec` and `isr_ed` takes `code_defer_ok`. Both hold their values until the next fault.
- R9: When `defer_bit` is 1, the next speculative load gets a token write regardless of its conditions, and `defer_bit` is 0 from the following cycle. Non-speculative loads neither use nor clear the bit.
- R10: `sw_wr_en` loads `sw_wr_val` into `defer_bit` on the next edge. If a speculative load consumes the bit in the same cycle, the write wins, and that load still sees the old value.
- R11: After reset, all results, `fault_code`, `isr_spec`, `isr_ed` and `defer_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_spec | input | 1 | The load is speculative |
| cond_hit | input | NCOND | Exception condition present, index 0 highest priority |
| cond_precl | input | NCOND | Condition is precluded |
| cond_dcr | input | NCOND | Condition is deferred by control-register setting |
| page_attr | input | 2 | 0 cacheable, 1 uncacheable, 2 limited speculation, 3 reserved |
| code_defer_ok | input | 1 | Code page permits deferral |
| spont_en | input | 1 | Spontaneous deferral enabled |
| spont_allow | input | 1 | Policy: spontaneous deferral permitted |
| sw_wr_en | input | 1 | Software write strobe for the one-shot bit |
| sw_wr_val | input | 1 | Value written to the one-shot bit |
| res_fault | output | 1 | Fault request for the previous cycle's load |
| res_token | output | 1 | Token-write strobe |
| res_normal | output | 1 | Normal-complete strobe |
| fault_code | output | $clog2(NCOND) | Priority index of the raised condition |
| isr_spec | output | 1 | Captured on fault: load was speculative |
| isr_ed | output | 1 | Captured on fault: code-page deferral permit |
| defer_bit | output | 1 | One-shot deferral bit |

## Verification
Every outcome, `fault_code`, the two status bits and the updated `defer_bit` are due on the clock edge that follows the cycle in which the load or write is presented. Nothing is due later. Each scenario task drives its inputs just after a falling edge and holds `ld_valid` or `sw_wr_en` for one cycle. It then samples at the next falling edge, which comes half a period after the one capturing register. Hold behaviour, such as the status bits across a token outcome or `defer_bit` across a non-speculative load, is checked at the same point after the intervening load.

// File: rtl/sldd_pkg.sv
package sldd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FAULT  = 2'd1,
        ST_TOKEN  = 2'd2,
        ST_NORMAL = 2'd3
    } sldd_state_e;

    typedef enum logic [1:0] {
        PG_CACHED   = 2'd0,
        PG_UNCACHED = 2'd1,
        PG_LIMSPEC  = 2'd2,
        PG_RSVD     = 2'd3
    } sldd_page_e;

endpackage

// File: rtl/sldd_prio_pick.sv
module sldd_prio_pick #(
    parameter int NCOND  = 8,
    parameter int CODE_W = $clog2(NCOND)
) (
    input  logic [NCOND-1:0]  req,
    output logic              any_o,
    output logic [CODE_W-1:0] code_o
);

    logic [NCOND-1:0] first;

    for (genvar i = 0; i < NCOND; i++) begin : g_first
        if (i == 0) begin : g_top
            assign first[i] = req[i];
        end else begin : g_rest
            assign first[i] = req[i] & ~(|req[i-1:0]);
        end
    end

    assign any_o = |req;

    always_comb begin
        code_o = '0;
        for (int i = 0; i < NCOND; i++) begin
            if (first[i]) begin
                code_o = code_o | CODE_W'(i);
            end
        end
    end

    always_comb begin
        a_single_winner_r2 : assert ($onehot0(first));
    end

endmodule

// File: rtl/sldd_oneshot.sv
module sldd_oneshot (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_val,
    input  logic consume,
    output logic q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (wr_en) begin
            q <= wr_val;
        end else if (consume) begin
            q <= 1'b0;
        end
    end

    p_oneshot_clear_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !wr_en) |=> !q);

    p_sw_write_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wr_val)));

    p_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (!consume && !wr_en) |=> $stable(q));

endmodule

// File: rtl/sldd_decide.sv
module sldd_decide #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic              ld_spec,
    input  logic              any_cond,
    input  logic              live_any,
    input  logic [CODE_W-1:0] live_code,
    input  logic [1:0]        page_attr,
    input  logic              code_defer_ok,
    input  logic              spont_en,
    input  logic              spont_allow,
    input  logic              ed_q,
    output logic              consume,
    output logic              res_fault,
    output logic              res_token,
    output logic              res_normal,
    output logic [CODE_W-1:0] fault_code,
    output logic              isr_spec,
    output logic              isr_ed
);
    import sldd_pkg::*;

    sldd_state_e state_q, state_d;
    sldd_page_e  page;

    assign page    = sldd_page_e'(page_attr);
    assign consume = ld_valid && ld_spec && ed_q;

    // Decision order: one-shot, live fault, non-speculative complete,
    // masked conditions, page attribute, spontaneous policy.
    always_comb begin
        state_d = ST_IDLE;
        if (ld_valid) begin
            if (ld_spec && ed_q) begin
                state_d = ST_TOKEN;
            end else if (live_any) begin
                state_d = ST_FAULT;
            end else if (!ld_spec) begin
                state_d = ST_NORMAL;
            end else if (any_cond) begin
                state_d = ST_TOKEN;
            end else if (page != PG_CACHED) begin
                state_d = ST_TOKEN;
            end else if (spont_en && spont_allow) begin
                state_d = ST_TOKEN;
            end else begin
                state_d = ST_NORMAL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            fault_code <= '0;
            isr_spec   <= 1'b0;
            isr_ed     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_FAULT) begin
                fault_code <= live_code;
                isr_spec   <= ld_spec;
                isr_ed     <= code_defer_ok;
            end
        end
    end

    always_comb begin
        res_fault  = 1'b0;
        res_token  = 1'b0;
        res_normal = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_FAULT:  res_fault  = 1'b1;
            ST_TOKEN:  res_token  = 1'b1;
            ST_NORMAL: res_normal = 1'b1;
            default:   ;
        endcase
    end

    p_onehot_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_fault, res_token, res_normal}));

    p_respond_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> (res_fault || res_token || res_normal));

    p_quiet_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !(res_fault || res_token || res_normal));

    p_ns_no_token_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_spec) |=> !res_token);

    p_oneshot_token_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_spec && ed_q) |=> res_token);

    p_isr_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        !res_fault |-> (isr_spec == $past(isr_spec) || $past(!rst_n)));

endmodule

// File: rtl/spec_ld_defer_unit.sv
module spec_ld_defer_unit #(
    parameter int NCOND  = 8,
    localparam int CODE_W = $clog2(NCOND)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic              ld_spec,
    input  logic [NCOND-1:0]  cond_hit,
    input  logic [NCOND-1:0]  cond_precl,
    input  logic [NCOND-1:0]  cond_dcr,
    input  logic [1:0]        page_attr,
    input  logic              code_defer_ok,
    input  logic              spont_en,
    input  logic              spont_allow,
    input  logic              sw_wr_en,
    input  logic              sw_wr_val,
    output logic              res_fault,
    output logic              res_token,
    output logic              res_normal,
    output logic [CODE_W-1:0] fault_code,
    output logic              isr_spec,
    output logic              isr_ed,
    output logic              defer_bit
);

    logic [NCOND-1:0]  live_vec;
    logic              live_any;
    logic [CODE_W-1:0] live_code;
    logic              consume;

    // Control-register deferral only removes conditions of speculative loads.
    assign live_vec = cond_hit & ~cond_precl & (ld_spec ? ~cond_dcr : '1);

    sldd_prio_pick #(.NCOND(NCOND), .CODE_W(CODE_W)) u_pick (
        .req    (live_vec),
        .any_o  (live_any),
        .code_o (live_code)
    );

    sldd_oneshot u_oneshot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sw_wr_en),
        .wr_val  (sw_wr_val),
        .consume (consume),
        .q       (defer_bit)
    );

    sldd_decide #(.CODE_W(CODE_W)) u_decide (
        .clk           (clk),
        .rst_n         (rst_n),
        .ld_valid      (ld_valid),
        .ld_spec       (ld_spec),
        .any_cond      (|cond_hit),
        .live_any      (live_any),
        .live_code     (live_code),
        .page_attr     (page_attr),
        .code_defer_ok (code_defer_ok),
        .spont_en      (spont_en),
        .spont_allow   (spont_allow),
        .ed_q          (defer_bit),
        .consume       (consume),
        .res_fault     (res_fault),
        .res_token     (res_token),
        .res_normal    (res_normal),
        .fault_code    (fault_code),
        .isr_spec      (isr_spec),
        .isr_ed        (isr_ed)
    );

    p_fault_code_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && live_any && !(ld_spec && defer_bit)) |=> (res_fault && fault_code == $past(live_code)));

endmodule

// File: tb/spec_ld_defer_unit_bench.sv
`timescale 1ns/1ps
module spec_ld_defer_unit_bench;

    localparam int NCOND = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ld_valid, ld_spec;
    logic [7:0] cond_hit, cond_precl, cond_dcr;
    logic [1:0] page_attr;
    logic       code_defer_ok, spont_en, spont_allow, sw_wr_en, sw_wr_val;
    logic       res_fault, res_token, res_normal;
    logic [2:0] fault_code;
    logic       isr_spec, isr_ed, defer_bit;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spec_ld_defer_unit #(.NCOND(NCOND)) u_spec_ld_defer_unit (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_spec(ld_spec),
        .cond_hit(cond_hit), .cond_precl(cond_precl), .cond_dcr(cond_dcr),
        .page_attr(page_attr), .code_defer_ok(code_defer_ok),
        .spont_en(spont_en), .spont_allow(spont_allow),
        .sw_wr_en(sw_wr_en), .sw_wr_val(sw_wr_val),
        .res_fault(res_fault), .res_token(res_token), .res_normal(res_normal),
        .fault_code(fault_code), .isr_spec(isr_spec), .isr_ed(isr_ed),
        .defer_bit(defer_bit)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // exp: 0 none, 1 fault, 2 token, 3 normal
    task automatic chk_res(input string req, input int exp, input int code);
        chk({req, " outcome"}, {29'd0, res_fault, res_token, res_normal},
            exp == 1 ? 4 : exp == 2 ? 2 : exp == 3 ? 1 : 0);
        if (exp == 1) chk({req, " code"}, fault_code, code);
    endtask

    task automatic idle_inputs();
        ld_valid = 0; ld_spec = 0; cond_hit = '0; cond_precl = '0; cond_dcr = '0;
        page_attr = 2'd0; code_defer_ok = 0; spont_en = 0; spont_allow = 0;
        sw_wr_en = 0; sw_wr_val = 0;
    endtask

    // Present one load for one cycle; return at the falling edge where the result is due.
    task automatic issue(input logic spec, input logic [7:0] hit, input logic [7:0] precl,
                         input logic [7:0] dcr, input logic [1:0] attr, input logic cdok,
                         input logic sen, input logic sal);
        @(negedge clk);
        ld_valid = 1; ld_spec = spec; cond_hit = hit; cond_precl = precl; cond_dcr = dcr;
        page_attr = attr; code_defer_ok = cdok; spont_en = sen; spont_allow = sal;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic sw_write(input logic v);
        @(negedge clk);
        sw_wr_en = 1; sw_wr_val = v;
        @(negedge clk);
        sw_wr_en = 0;
    endtask

    task automatic t_reset();
        chk_res("R11", 0, 0);
        chk("R11 code", fault_code, 0);
        chk("R11 isr_spec", isr_spec, 0);
        chk("R11 isr_ed", isr_ed, 0);
        chk("R11 defer_bit", defer_bit, 0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        @(negedge clk);
        chk_res("R1 idle", 0, 0);
        issue(1, 8'h00, 8'h00, 8'h00, 2'd0, 0, 0, 0);
        chk_res("R1 respond", 3, 0);
        @(negedge clk);
        chk_res("R1 quiet after load", 0, 0);
    endtask

    task automatic t_fault_prio();
        issue(1, 8'h24, 8'h00, 8'h00, 2'd0, 0, 0, 0);
        chk_res("R2 lowest index", 1, 2);
        issue(1, 8'h80, 8'h00, 8'h00, 2'd1, 0, 1, 1);
        chk_res("R2 index 7", 1, 7);
        issue(1, 8'hFF, 8'h00, 8'h00, 2'd0, 0, 0, 0);
        chk_res("R2 index 0", 1, 0);
    endtask

    task automatic t_mask_skip();
        issue(1, 8'h26, 8'h00, 8'h06, 2'd0, 0, 0, 0);
        chk_res("R3 dcr skipped", 1, 5);
        issue(1, 8'h0A, 8'h02, 8'h00, 2'd0, 0, 0, 0);
        chk_res("R3 precluded skipped", 1, 3);
    endtask

    task automatic t_all_deferred();
        issue(1, 8'h05, 8'h04, 8'h01, 2'd0, 0, 0, 0);
        chk_res("R4 all masked", 2, 0);
    endtask

    task automatic t_attr();
        issue(1, 8'h00, 8'h00, 8'h00, 2'd1, 0, 0, 0);
        chk_res("R5 uncacheable", 2, 0);
        issue(1, 8'h00, 8'h00, 8'h00, 2'd2, 0, 0, 0);
        chk_res("R5 limited", 2, 0);
        issue(1, 8'h00, 8'h00, 8'h00, 2'd3, 0, 0, 0);
        chk_res("R5 reserved", 2, 0);
        issue(1, 8'h00, 8'h00, 8'h00, 2'd0, 0, 0, 0);
        chk_res("R5 cacheable", 3, 0);
    endtask

    task automatic t_spont();
        issue(1, 8'h00, 8'h00, 8'h00, 2'd0, 0, 1, 1);
        chk_res("R6 enabled+allowed", 2, 0);
        issue(1, 8'h00, 8'h00, 8'h00, 2'd0, 0, 1, 0);
        chk_res("R6 not allowed", 3, 0);
        issue(1, 8'h00, 8'h00, 8'h00, 2'd0, 0, 0, 1);
        chk_res("R6 not enabled", 3, 0);
    endtask

    task automatic t_nonspec();
        issue(0, 8'h04, 8'h00, 8'h04, 2'd0, 0, 0, 0);
        chk_res("R7 dcr ignored", 1, 2);
        issue(0, 8'h0C, 8'h0C, 8'h00, 2'd0, 0, 0, 0);
        chk_res("R7 precluded", 3, 0);
        issue(0, 8'h00, 8'h00, 8'h00, 2'd2, 0, 1, 1);
        chk_res("R7 attr+spont", 3, 0);
    endtask

    task automatic t_isr();
        issue(1, 8'h01, 8'h00, 8'h00, 2'd0, 1, 0, 0);
        chk_res("R8 fault", 1, 0);
        chk("R8 isr_spec", isr_spec, 1);
        chk("R8 isr_ed", isr_ed, 1);
        issue(1, 8'h00, 8'h00, 8'h00, 2'd1, 0, 0, 0);
        chk("R8 hold spec", isr_spec, 1);
        chk("R8 hold ed", isr_ed, 1);
        issue(0, 8'h10, 8'h00, 8'h00, 2'd0, 0, 0, 0);
        chk("R8 ns spec", isr_spec, 0);
        chk("R8 ns ed", isr_ed, 0);
    endtask

    task automatic t_oneshot();
        sw_write(1);
        chk("R10 set", defer_bit, 1);
        issue(0, 8'h02, 8'h00, 8'h00, 2'd0, 0, 0, 0);
        chk_res("R9 nonspec ignores", 1, 1);
        chk("R9 not consumed", defer_bit, 1);
        issue(1, 8'h01, 8'h00, 8'h00, 2'd0, 0, 0, 0);
        chk_res("R9 forced token", 2, 0);
        chk("R9 cleared", defer_bit, 0);
        issue(1, 8'h01, 8'h00, 8'h00, 2'd0, 0, 0, 0);
        chk_res("R9 one instr only", 1, 0);
    endtask

    task automatic t_collide();
        sw_write(1);
        @(negedge clk);
        ld_valid = 1; ld_spec = 1; cond_hit = 8'h08; sw_wr_en = 1; sw_wr_val = 1;
        @(negedge clk);
        idle_inputs();
        chk_res("R10 old value used", 2, 0);
        chk("R10 write wins", defer_bit, 1);
        sw_write(0);
        chk("R10 clear", defer_bit, 0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_fault_prio();
        t_mask_skip();
        t_all_deferred();
        t_attr();
        t_spont();
        t_nonspec();
        t_isr();
        t_oneshot();
        t_collide();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule